// File: doc/BRIEF.md
# Reference-Counted Peripheral Power Gate

This block arbitrates power for a serial-bus controller shared by several software or hardware clients. Each client raises a one-cycle enable request when it starts needing the controller and a one-cycle disable request when it is done. The block keeps a saturating reference count. When the count leaves zero, the block ungates the controller's clock, clears its status, and then turns on the module-enable and interrupt-enable lines. When the count returns to zero, the block does not cut power at once. It first waits until the job queue is empty, then until the bus has been released. Only then does it drop the module and interrupt enables and gate the clock.

After reset the block runs a short housekeeping phase. The clock is ungated and a control-clear strobe is held so the controller's control register starts from zero. The clock is then gated off again. An enable that arrives while a shutdown wait is running cancels the shutdown, and the controller stays on without a glitch on its enables.

The sequencer is a Moore machine with seven states. `PS_INIT` is the post-reset housekeeping phase. `PS_OFF` is gated and idle. `PS_WAKE` lasts one cycle, with the clock on and the status being cleared. `PS_ON` is fully enabled. `PS_DRAIN_Q` waits for the queue to empty. `PS_DRAIN_BUS` waits for the bus to go idle. `PS_SHUT` lasts one cycle, with the enables dropped and the clock still running.

The transitions are:
- INIT→OFF after `INIT_CYCLES` cycles.
- OFF→WAKE when the count is nonzero.
- WAKE→ON unconditionally.
- ON→DRAIN_Q when the count is zero.
- DRAIN_Q→DRAIN_BUS when the queue is empty.
- DRAIN_BUS→SHUT when the bus is not busy.
- DRAIN_Q→ON and DRAIN_BUS→ON (cancel) when the count is nonzero.
- SHUT→OFF unconditionally.

Top module: `refcnt_power_gate`

## Requirements
- R1: For `INIT_CYCLES` cycles after reset release, `clk_en` and `ctrl_clr` are 1, while `mod_en`, `irq_en`, `stat_clr` and `powered` are 0. Afterwards all of them are 0 until a wake.
- R2: An enable request alone raises `count` by one in the cycle after the request. Enable and disable requested in the same cycle leave `count` unchanged.
- R3: `count` saturates at 2^CNT_W−1. At that value, a further enable request leaves it unchanged.
- R4: A disable request alone lowers `count` by one when it is above zero. At zero it is ignored: `count` stays 0 and the enables stay off.
- R5: In the cycle after `count` becomes nonzero while gated, the block spends one cycle with `clk_en`=1, `stat_clr`=1 and `mod_en`=`irq_en`=0. From the next cycle on, `clk_en`, `mod_en` and `irq_en` are all 1.
- R6: In the cycle after `count` reaches zero while on, the block enters the queue wait. It keeps `clk_en`, `mod_en` and `irq_en` at 1 for as long as `queue_empty` is 0.
- R7: Once the queue is empty, the block keeps all enables at 1 for as long as `bus_busy` is 1.
- R8: Once the bus is idle, the block spends one cycle with `mod_en`=`irq_en`=0 and `clk_en`=1. In the following cycle `clk_en` is 0, so the module enable always falls while the clock is still running.
- R9: An enable request during either drain wait returns the block to the fully on state, and `mod_en` does not drop.
- R10: `powered` is 1 from the wake cycle through the shutdown cycle inclusive, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | One-cycle enable request from a client |
| dis_req | input | 1 | One-cycle disable request from a client |
| queue_empty | input | 1 | High when no transfer job is pending |
| bus_busy | input | 1 | High while the serial bus is held (before STOP) |
| clk_en | output | 1 | Enable for the controller's clock-gating cell |
| mod_en | output | 1 | Controller module-enable bit |
| irq_en | output | 1 | Controller interrupt-enable |
| stat_clr | output | 1 | Status-clear strobe during wake |
| ctrl_clr | output | 1 | Control-register clear strobe during post-reset init |
| powered | output | 1 | High from ungate until gate |
| count | output | CNT_W | Current reference count |

## Verification
The bench builds the block with `CNT_W`=4 and `INIT_CYCLES`=3. The narrow counter lets saturation at 15 be reached with a short burst of enables, and the bench then drains it back to zero. The longer init phase makes the housekeeping window visible across several cycles. The stimulus holds `queue_empty` low and `bus_busy` high across drain waits. It also cancels a shutdown from each wait state, hits disable at zero, and issues simultaneous requests. Every cycle is compared against a behavioural model.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [2:0] {
        PS_INIT      = 3'd0,
        PS_OFF       = 3'd1,
        PS_WAKE      = 3'd2,
        PS_ON        = 3'd3,
        PS_DRAIN_Q   = 3'd4,
        PS_DRAIN_BUS = 3'd5,
        PS_SHUT      = 3'd6
    } pwr_state_t;

    typedef struct packed {
        logic clk_en;
        logic mod_en;
        logic irq_en;
        logic stat_clr;
        logic ctrl_clr;
        logic powered;
    } pwr_out_t;

endpackage

// File: rtl/rpg_counter.sv
module rpg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    output logic [CNT_W-1:0] count,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             inc_ok;
    logic             dec_ok;

    assign inc_ok = en_req && !dis_req && (cnt_q != CNT_MAX);
    assign dec_ok = dis_req && !en_req && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_ok) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_ok) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count    = cnt_q;
    assign cnt_zero = (cnt_q == '0);

    // R2: a lone enable below the ceiling adds exactly one
    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && !dis_req && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

    // R3: the ceiling holds under further enables
    assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && !dis_req && count == CNT_MAX) |=> (count == CNT_MAX));

    // R4: disable at zero leaves the count at zero
    assert_dis_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && !en_req && count == '0) |=> (count == '0));

endmodule

// File: rtl/rpg_seq.sv
module rpg_seq
    import rpg_pkg::*;
#(
    parameter int INIT_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cnt_zero,
    input  logic     queue_empty,
    input  logic     bus_busy,
    output pwr_out_t outs
);
    localparam int TW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(INIT_CYCLES - 1);

    pwr_state_t    state_q, state_d;
    logic [TW-1:0] tmr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_INIT:      if (tmr_q == T_LAST) state_d = PS_OFF;
            PS_OFF:       if (!cnt_zero) state_d = PS_WAKE;
            PS_WAKE:      state_d = PS_ON;
            PS_ON:        if (cnt_zero) state_d = PS_DRAIN_Q;
            PS_DRAIN_Q: begin
                if (!cnt_zero)        state_d = PS_ON;
                else if (queue_empty) state_d = PS_DRAIN_BUS;
            end
            PS_DRAIN_BUS: begin
                if (!cnt_zero)     state_d = PS_ON;
                else if (!bus_busy) state_d = PS_SHUT;
            end
            PS_SHUT:      state_d = PS_OFF;
            default:      state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_INIT;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_INIT && tmr_q != T_LAST) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    always_comb begin
        outs = '0;
        unique case (state_q)
            PS_INIT: begin
                outs.clk_en   = 1'b1;
                outs.ctrl_clr = 1'b1;
            end
            PS_OFF: begin
                outs = '0;
            end
            PS_WAKE: begin
                outs.clk_en   = 1'b1;
                outs.stat_clr = 1'b1;
                outs.powered  = 1'b1;
            end
            PS_ON, PS_DRAIN_Q, PS_DRAIN_BUS: begin
                outs.clk_en  = 1'b1;
                outs.mod_en  = 1'b1;
                outs.irq_en  = 1'b1;
                outs.powered = 1'b1;
            end
            PS_SHUT: begin
                outs.clk_en  = 1'b1;
                outs.powered = 1'b1;
            end
            default: outs = '0;
        endcase
    end

    // R6: the queue wait holds while jobs remain and nobody re-enables
    assert_queue_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRAIN_Q && cnt_zero && !queue_empty) |=> (state_q == PS_DRAIN_Q));

    // R7: the bus wait holds while the bus is held
    assert_bus_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRAIN_BUS && cnt_zero && bus_busy) |=> (state_q == PS_DRAIN_BUS));

    // R9: a nonzero count during a drain wait returns to fully on
    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_DRAIN_Q || state_q == PS_DRAIN_BUS) && !cnt_zero) |=> (state_q == PS_ON));

endmodule

// File: rtl/refcnt_power_gate.sv
module refcnt_power_gate
    import rpg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int INIT_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic             queue_empty,
    input  logic             bus_busy,
    output logic             clk_en,
    output logic             mod_en,
    output logic             irq_en,
    output logic             stat_clr,
    output logic             ctrl_clr,
    output logic             powered,
    output logic [CNT_W-1:0] count
);
    logic     cnt_zero;
    pwr_out_t outs;

    rpg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (en_req),
        .dis_req  (dis_req),
        .count    (count),
        .cnt_zero (cnt_zero)
    );

    rpg_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_zero    (cnt_zero),
        .queue_empty (queue_empty),
        .bus_busy    (bus_busy),
        .outs        (outs)
    );

    assign clk_en   = outs.clk_en;
    assign mod_en   = outs.mod_en;
    assign irq_en   = outs.irq_en;
    assign stat_clr = outs.stat_clr;
    assign ctrl_clr = outs.ctrl_clr;
    assign powered  = outs.powered;

    // R8: the module enable never falls with the clock already gated
    assert_gate_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_en) |-> clk_en);

    // R5: the module enable only rises one cycle after a status clear
    assert_wake_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_en) |-> $past(stat_clr));

endmodule

// File: tb/refcnt_power_gate_test.sv
`timescale 1ns/1ps
module refcnt_power_gate_test;
    localparam int CW = 4;
    localparam int IC = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, queue_empty = 1'b1, bus_busy = 1'b0;
    logic clk_en, mod_en, irq_en, stat_clr, ctrl_clr, powered;
    logic [CW-1:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    // behavioural model: phase 0 init,1 off,2 wake,3 on,4 queue wait,5 bus wait,6 shut
    int m_cnt = 0;
    int m_ph = 0;
    int m_init = 0;

    always #2.5 clk = ~clk;

    refcnt_power_gate #(.CNT_W(CW), .INIT_CYCLES(IC)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .queue_empty(queue_empty), .bus_busy(bus_busy),
        .clk_en(clk_en), .mod_en(mod_en), .irq_en(irq_en),
        .stat_clr(stat_clr), .ctrl_clr(ctrl_clr), .powered(powered),
        .count(count)
    );

    always @(posedge clk) begin
        int c;
        c = m_cnt;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0; m_init = 0;
        end else begin
            case (m_ph)
                0: if (m_init == IC - 1) m_ph = 1; else m_init = m_init + 1;
                1: if (c != 0) m_ph = 2;
                2: m_ph = 3;
                3: if (c == 0) m_ph = 4;
                4: if (c != 0) m_ph = 3; else if (queue_empty) m_ph = 5;
                5: if (c != 0) m_ph = 3; else if (!bus_busy) m_ph = 6;
                default: m_ph = 1;
            endcase
            if (en_req && !dis_req && c < MAXC) m_cnt = c + 1;
            else if (dis_req && !en_req && c > 0) m_cnt = c - 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic string ph_tag(input int p);
        case (p)
            0: return "R1";
            1: return "R8";
            2: return "R5";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(negedge clk) begin
        if (live && rst_n) begin
            string t;
            t = ph_tag(m_ph);
            chk("R2 count", int'(count), m_cnt);
            chk({t, " clk_en"}, int'(clk_en), int'(m_ph != 1));
            chk({t, " mod_en"}, int'(mod_en), int'(m_ph >= 3 && m_ph <= 5));
            chk({t, " irq_en"}, int'(irq_en), int'(m_ph >= 3 && m_ph <= 5));
            chk({t, " stat_clr"}, int'(stat_clr), int'(m_ph == 2));
            chk("R1 ctrl_clr", int'(ctrl_clr), int'(m_ph == 0));
            chk("R10 powered", int'(powered), int'(m_ph >= 2));
        end
    end

    task automatic step(input bit e, input bit d);
        @(negedge clk);
        en_req = e; dis_req = d;
        @(negedge clk);
        en_req = 0; dis_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        live = 1'b1;
        #0.1;
        chk("R1 reset clk_en", int'(clk_en), 1);
        idle(6);
        step(0, 1); step(0, 1);
        chk("R4 disable at zero", int'(count), 0);
        chk("R4 still off", int'(mod_en), 0);
        queue_empty = 0; bus_busy = 1;
        step(1, 0); idle(3);
        chk("R5 on", int'(mod_en), 1);
        step(1, 0); step(1, 1); step(0, 1);
        chk("R2 count after mixed", int'(count), 1);
        step(0, 1); idle(5);
        chk("R6 held by queue", int'(mod_en), 1);
        step(1, 0); idle(2);
        chk("R9 cancel from queue wait", int'(mod_en), 1);
        step(0, 1); idle(2);
        queue_empty = 1; idle(5);
        chk("R7 held by bus", int'(mod_en), 1);
        step(1, 0); idle(2);
        chk("R9 cancel from bus wait", int'(mod_en), 1);
        step(0, 1); idle(3);
        bus_busy = 0; idle(5);
        chk("R8 gated", int'(clk_en), 0);
        for (int i = 0; i < MAXC + 4; i++) step(1, 0);
        chk("R3 saturated", int'(count), MAXC);
        for (int i = 0; i < MAXC; i++) step(0, 1);
        idle(6);
        chk("R8 off after drain", int'(powered), 0);
        step(1, 0); step(0, 1); idle(8);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule